// File: doc/BRIEF.md
# Single/Half Precision Floating-Point Format Converter

This block is a purely combinational converter between 32-bit single-precision and 16-bit half-precision floating-point words. A direction input picks the path. On the narrowing path a single-precision word is rounded into half precision under a 2-bit rounding mode, or truncated when a force-truncate flag is raised. On the widening path a half-precision word is extended exactly into single precision. Both paths share one 32-bit result port. A narrowed result sits in the low half of that port, and the upper half is driven to zero.

On the narrowing path, single-precision subnormals and any value too small to matter become a signed zero before any rounding is done. Values below the half-precision normal range come out as half-precision subnormals. Overflow either saturates or becomes infinity, depending on the rounding direction. On the widening path, half-precision subnormals are renormalised. A NaN on either path becomes the canonical NaN of the target format. Infinities keep their sign.

There is no state. The house naming and layout are kept, and the state-machine conventions do not apply.

Top module: `fpcvt_top`

## Requirements
- R1: With `to_half_i`=1 the result is `{16'h0000, half_result}`. With `to_half_i`=0 the result is the widened 32-bit word. The input of the unused direction has no effect.
- R2: Narrowing a single-precision NaN (exponent 0xFF, fraction non-zero) gives 0x7FFF. Narrowing +inf gives 0x7C00 and narrowing -inf gives 0xFC00.
- R3: Narrowing any input whose biased exponent field (bits 30:23) is 93 or less gives a signed zero (sign bit 15 = input bit 31, all other bits 0), whatever the rounding mode. This covers zeros and subnormals.
- R4: Narrowing a normal value rebiases the exponent by -112 and keeps the 11 leading significand bits. The discarded bits are rounded by `rmode_i`: 0 = to nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero. The sign is always kept.
- R5: With `trunc_i`=1, narrowing discards the extra significand bits toward zero whatever `rmode_i` says.
- R6: When the rebiased exponent is 0 or below, the result is a half-precision subnormal (exponent field 0). The significand is shifted right by an extra (1 - rebiased exponent) bits and then rounded. A round-up that reaches 0x0400 becomes the smallest normal.
- R7: When the result exceeds the half-precision range, before or after rounding, it is ±infinity (0x7C00 with sign) under round-to-nearest or a magnitude-increasing mode. Otherwise it is ±0x7BFF.
- R8: Widening a half NaN (exponent 0x1F, fraction non-zero) gives 0x7FFFFFFF. Widening ±inf gives 0x7F800000 or 0xFF800000.
- R9: Widening a normal half adds 112 to the exponent and shifts the fraction left by 13. A signed zero stays a signed zero.
- R10: Widening a half subnormal gives a normal single whose exponent is 103 plus the position of the leading fraction one. The fraction bits below that one are left-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| to_half_i | input | 1 | 1 = narrow single to half, 0 = widen half to single |
| rmode_i | input | 2 | Rounding mode for narrowing (0 nearest-even, 1 down, 2 up, 3 toward zero) |
| trunc_i | input | 1 | Forces truncation toward zero when narrowing |
| single_i | input | 32 | Single-precision operand for narrowing |
| half_i | input | 16 | Half-precision operand for widening |
| res_o | output | 32 | Converted word (narrowed result in bits 15:0) |

## Verification
The bench targets the exponent edges of the narrowing path.

- At exponent 93 against 94, a converter that rounded before flushing would emit 0x0001 under round-up at 93.
- A tie at the largest finite value must carry into infinity under nearest-even, but saturate at 0x7BFF toward zero. A design that ignored the carry would emit a bogus exponent of 31 with a zero fraction only by accident.
- A rounding mode that is not folded by the sign would round negative values the wrong way.
- The truncate flag must override every mode.

On the widening side, subnormals at both ends of the fraction are checked. A design with a wrong leading-one search would produce an exponent off by one or keep the hidden bit in the fraction.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

    localparam int SP_W       = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_MAN_W   = 23;
    localparam int HP_W       = 16;
    localparam int HP_EXP_W   = 5;
    localparam int HP_MAN_W   = 10;
    localparam int SP_BIAS    = 127;
    localparam int HP_BIAS    = 15;
    localparam int BIAS_DIFF  = SP_BIAS - HP_BIAS;
    localparam int SIG_W      = SP_MAN_W + 1;
    localparam int BASE_SH    = SP_MAN_W - HP_MAN_W;
    localparam int KEEP_W     = HP_MAN_W + 1;
    localparam int FLUSH_EXP  = 93;
    localparam int XTRA_W     = 20;
    localparam int XSH_W      = 5;
    localparam int SUB_LEAD_BASE = SP_BIAS - HP_BIAS - HP_MAN_W + 1 - 1 + 1 - 1 - 8;

    localparam logic [HP_W-1:0] HP_QNAN = 16'h7fff;
    localparam logic [SP_W-1:0] SP_QNAN = 32'h7fff_ffff;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_DOWN    = 2'd1,
        RND_UP      = 2'd2,
        RND_ZERO    = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        MAG_NEAREST = 2'd0,
        MAG_CHOP    = 2'd1,
        MAG_AWAY    = 2'd2
    } mag_rnd_e;

    function automatic mag_rnd_e fold_mode(input logic [1:0] mode, input logic sign,
                                           input logic chop);
        mag_rnd_e r;
        if (chop) begin
            r = MAG_CHOP;
        end else begin
            unique case (rnd_mode_e'(mode))
                RND_NEAREST: r = MAG_NEAREST;
                RND_DOWN:    r = sign ? MAG_AWAY : MAG_CHOP;
                RND_UP:      r = sign ? MAG_CHOP : MAG_AWAY;
                default:     r = MAG_CHOP;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/fpcvt_round_shift.sv
module fpcvt_round_shift
    import fpcvt_pkg::*;
#(
    parameter int IN_W  = SIG_W,
    parameter int OUT_W = KEEP_W,
    parameter int EXT_W = XTRA_W,
    parameter int SH_W  = XSH_W
) (
    input  logic [IN_W-1:0]  sig_i,
    input  logic [SH_W-1:0]  extra_sh_i,
    input  mag_rnd_e         mode_i,
    output logic [OUT_W:0]   q_o
);
    localparam int FRAC_W = IN_W - OUT_W + EXT_W;
    localparam int TOT_W  = IN_W + EXT_W;

    logic [TOT_W-1:0]  shifted;
    logic [OUT_W-1:0]  kept;
    logic              half_bit;
    logic              sticky;
    logic              bump;

    always_comb begin
        shifted  = {sig_i, {EXT_W{1'b0}}} >> extra_sh_i;
        kept     = shifted[TOT_W-1:FRAC_W];
        half_bit = shifted[FRAC_W-1];
        sticky   = |shifted[FRAC_W-2:0];
        unique case (mode_i)
            MAG_NEAREST: bump = half_bit & (sticky | kept[0]);
            MAG_AWAY:    bump = half_bit | sticky;
            default:     bump = 1'b0;
        endcase
        q_o = {1'b0, kept} + {{OUT_W{1'b0}}, bump};
    end
endmodule

// File: rtl/fpcvt_narrow.sv
module fpcvt_narrow
    import fpcvt_pkg::*;
(
    input  logic [SP_W-1:0] sp_i,
    input  logic [1:0]      rmode_i,
    input  logic            trunc_i,
    output logic [HP_W-1:0] hp_o
);
    logic                 sgn;
    logic [SP_EXP_W-1:0]  exp_in;
    logic [SP_MAN_W-1:0]  man_in;
    logic                 is_special;
    logic                 is_nan;
    logic                 is_tiny;
    logic signed [9:0]    exp_rb;
    logic signed [9:0]    exp_adj;
    logic signed [9:0]    exp_fin;
    logic signed [9:0]    xsh_full;
    logic [XSH_W-1:0]     xsh;
    mag_rnd_e             mode;
    logic [KEEP_W:0]      q;
    logic [HP_EXP_W-1:0]  exp_out;
    logic [HP_MAN_W-1:0]  man_out;
    logic                 ovf;

    always_comb begin
        sgn        = sp_i[SP_W-1];
        exp_in     = sp_i[SP_W-2:SP_MAN_W];
        man_in     = sp_i[SP_MAN_W-1:0];
        is_special = &exp_in;
        is_nan     = is_special & (|man_in);
        is_tiny    = exp_in <= SP_EXP_W'(FLUSH_EXP);
        exp_rb     = $signed({2'b00, exp_in}) - 10'sd112;
        mode       = fold_mode(rmode_i, sgn, trunc_i);
        if (exp_rb <= 10'sd0) begin
            xsh_full = 10'sd1 - exp_rb;
            exp_adj  = 10'sd1;
        end else begin
            xsh_full = 10'sd0;
            exp_adj  = exp_rb;
        end
        xsh = xsh_full[XSH_W-1:0];
    end

    fpcvt_round_shift #(
        .IN_W (SIG_W),
        .OUT_W(KEEP_W),
        .EXT_W(XTRA_W),
        .SH_W (XSH_W)
    ) round_i (
        .sig_i     ({1'b1, man_in}),
        .extra_sh_i(xsh),
        .mode_i    (mode),
        .q_o       (q)
    );

    always_comb begin
        exp_fin = exp_adj;
        if (q[KEEP_W]) begin
            exp_fin = exp_adj + 10'sd1;
            man_out = q[KEEP_W-1:1];
            exp_out = exp_fin[HP_EXP_W-1:0];
        end else if (q[KEEP_W-1]) begin
            man_out = q[HP_MAN_W-1:0];
            exp_out = exp_fin[HP_EXP_W-1:0];
        end else begin
            man_out = q[HP_MAN_W-1:0];
            exp_out = '0;
        end
        ovf = exp_fin >= 10'sd31;

        if (is_nan) begin
            hp_o = HP_QNAN;
        end else if (is_special) begin
            hp_o = {sgn, {HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
        end else if (is_tiny) begin
            hp_o = {sgn, {(HP_W-1){1'b0}}};
        end else if (ovf) begin
            if (mode == MAG_CHOP)
                hp_o = {sgn, {(HP_EXP_W-1){1'b1}}, 1'b0, {HP_MAN_W{1'b1}}};
            else
                hp_o = {sgn, {HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
        end else begin
            hp_o = {sgn, exp_out, man_out};
        end
    end
endmodule

// File: rtl/fpcvt_widen.sv
module fpcvt_widen
    import fpcvt_pkg::*;
(
    input  logic [HP_W-1:0] hp_i,
    output logic [SP_W-1:0] sp_o
);
    logic                 sgn;
    logic [HP_EXP_W-1:0]  exp_in;
    logic [HP_MAN_W-1:0]  man_in;
    logic [3:0]           lead;
    logic [HP_MAN_W-1:0]  man_sub;
    logic [SP_EXP_W-1:0]  exp_sub;
    logic [SP_EXP_W-1:0]  exp_nrm;

    always_comb begin
        sgn    = hp_i[HP_W-1];
        exp_in = hp_i[HP_W-2:HP_MAN_W];
        man_in = hp_i[HP_MAN_W-1:0];
        lead   = '0;
        for (int i = 0; i < HP_MAN_W; i++) begin
            if (man_in[i]) lead = 4'(i);
        end
        man_sub = man_in << (4'(HP_MAN_W) - lead);
        exp_sub = 8'd103 + {4'b0000, lead};
        exp_nrm = {3'b000, exp_in} + 8'(BIAS_DIFF);

        if (&exp_in) begin
            if (|man_in)
                sp_o = SP_QNAN;
            else
                sp_o = {sgn, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
        end else if (exp_in == '0) begin
            if (man_in == '0)
                sp_o = {sgn, {(SP_W-1){1'b0}}};
            else
                sp_o = {sgn, exp_sub, man_sub, {BASE_SH{1'b0}}};
        end else begin
            sp_o = {sgn, exp_nrm, man_in, {BASE_SH{1'b0}}};
        end
    end
endmodule

// File: rtl/fpcvt_top.sv
module fpcvt_top
    import fpcvt_pkg::*;
(
    input  logic              to_half_i,
    input  logic [1:0]        rmode_i,
    input  logic              trunc_i,
    input  logic [SP_W-1:0]   single_i,
    input  logic [HP_W-1:0]   half_i,
    output logic [SP_W-1:0]   res_o
);
    logic [HP_W-1:0] narrow_res;
    logic [SP_W-1:0] widen_res;

    fpcvt_narrow narrow_i (
        .sp_i   (single_i),
        .rmode_i(rmode_i),
        .trunc_i(trunc_i),
        .hp_o   (narrow_res)
    );

    fpcvt_widen widen_i (
        .hp_i(half_i),
        .sp_o(widen_res)
    );

    always_comb begin
        if (to_half_i)
            res_o = {{(SP_W-HP_W){1'b0}}, narrow_res};
        else
            res_o = widen_res;
    end
endmodule

// File: rtl/fpcvt_top_chk.sv
module fpcvt_top_chk (
    input  logic        to_half_i,
    input  logic [1:0]  rmode_i,
    input  logic        trunc_i,
    input  logic [31:0] single_i,
    input  logic [15:0] half_i,
    input  logic [31:0] res_o
);
    logic sp_nan;
    logic hp_nan;

    always_comb begin
        sp_nan = (&single_i[30:23]) & (|single_i[22:0]);
        hp_nan = (&half_i[14:10]) & (|half_i[9:0]);
        if (to_half_i) begin
            p_upper_zero_r1: assert (res_o[31:16] == 16'h0000)
                else $error("upper half not zero while narrowing");
            if (sp_nan) begin
                p_nan_narrow_r2: assert (res_o[15:0] == 16'h7fff)
                    else $error("narrowed NaN not canonical");
            end
            if (single_i[30:23] <= 8'd93) begin
                p_tiny_zero_r3: assert (res_o[15:0] == {single_i[31], 15'h0})
                    else $error("tiny input not flushed to signed zero");
            end
            if (!sp_nan) begin
                p_sign_kept_r4: assert (res_o[15] == single_i[31])
                    else $error("narrowing lost the sign");
            end
            if ((rmode_i == 2'd3 || trunc_i) && !(&single_i[30:23])) begin
                p_no_overflow_r7: assert (res_o[14:10] != 5'h1f)
                    else $error("toward-zero narrowing reached infinity");
            end
        end else begin
            if (hp_nan) begin
                p_nan_widen_r8: assert (res_o == 32'h7fffffff)
                    else $error("widened NaN not canonical");
            end else begin
                p_sign_kept_r9: assert (res_o[31] == half_i[15])
                    else $error("widening lost the sign");
            end
            if (half_i[14:10] == 5'h00 && half_i[9:0] != 10'h000) begin
                p_sub_range_r10: assert (res_o[30:23] >= 8'd103 && res_o[30:23] <= 8'd112)
                    else $error("widened subnormal exponent out of range");
            end
        end
    end
endmodule

bind fpcvt_top fpcvt_top_chk chk_i (
    .to_half_i(to_half_i),
    .rmode_i  (rmode_i),
    .trunc_i  (trunc_i),
    .single_i (single_i),
    .half_i   (half_i),
    .res_o    (res_o)
);

// File: tb/fpcvt_top_tb_top.sv
`timescale 1ns/1ps
module fpcvt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        to_half_i;
    logic [1:0]  rmode_i;
    logic        trunc_i;
    logic [31:0] single_i;
    logic [15:0] half_i;
    logic [31:0] res_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    fpcvt_top dut_i (
        .to_half_i(to_half_i),
        .rmode_i  (rmode_i),
        .trunc_i  (trunc_i),
        .single_i (single_i),
        .half_i   (half_i),
        .res_o    (res_o)
    );

    function automatic logic [15:0] model_narrow(logic [31:0] w, logic [1:0] rm, bit tr);
        bit     s = w[31];
        int     e = int'(w[30:23]);
        longint m, p2, q, r;
        int     ue, t, k, ef;
        bit     chop, away, near;
        logic [14:0] mag;
        if (e == 255) return (w[22:0] != 0) ? 16'h7fff : {s, 15'h7c00};
        if (e <= 93) return {s, 15'h0};
        near = (rm == 2'd0) && !tr;
        away = !tr && ((rm == 2'd2 && !s) || (rm == 2'd1 && s));
        chop = !near && !away;
        m  = longint'(w[22:0]) + 64'sd8388608;
        ue = e - 127;
        t  = ((ue < -14) ? -14 : ue) - 10;
        k  = t - (e - 150);
        p2 = 64'sd1 <<< k;
        q  = m / p2;
        r  = m % p2;
        if (near && ((2 * r > p2) || (2 * r == p2 && q[0]))) q++;
        if (away && r != 0) q++;
        if (q == 2048) begin q = 1024; t++; end
        if (q >= 1024) begin
            ef = t + 25;
            if (ef >= 31) mag = chop ? 15'h7bff : 15'h7c00;
            else mag = 15'((ef << 10) + int'(q - 1024));
        end else begin
            mag = 15'(q);
        end
        return {s, mag};
    endfunction

    function automatic logic [31:0] model_widen(logic [15:0] h);
        bit s = h[15];
        int e = int'(h[14:10]);
        int v = int'(h[9:0]);
        int ex;
        if (e == 31) return (v != 0) ? 32'h7fffffff : {s, 31'h7f800000};
        if (e == 0 && v == 0) return {s, 31'h0};
        if (e == 0) ex = -24;
        else begin v = v + 1024; ex = e - 25; end
        while (v < 1024) begin v = v * 2; ex--; end
        return {s, 8'(ex + 10 + 127), 23'((v - 1024) << 13)};
    endfunction

    task automatic apply(bit th, logic [1:0] rm, bit tr, logic [31:0] sw, logic [15:0] hw);
        @(posedge clk);
        #1;
        to_half_i = th; rmode_i = rm; trunc_i = tr; single_i = sw; half_i = hw;
    endtask

    task automatic compare(string tag, logic [31:0] expv);
        @(negedge clk);
        n_tests++;
        if (res_o !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (th=%0b rm=%0d tr=%0b s=%h h=%h)",
                     tag, res_o, expv, to_half_i, rmode_i, trunc_i, single_i, half_i);
        end
    endtask

    task automatic vec(bit th, logic [1:0] rm, bit tr, logic [31:0] sw, logic [15:0] hw,
                       logic [31:0] expv, string tag);
        apply(th, rm, tr, sw, hw);
        compare(tag, expv);
    endtask

    function automatic string tag_narrow(logic [31:0] sw, bit tr, logic [15:0] ev);
        if (sw[30:23] == 8'hff) return "R2";
        if (sw[30:23] <= 8'd93) return "R3";
        if (ev[14:0] >= 15'h7bff) return "R7";
        if (ev[14:10] == 5'h0) return "R6";
        if (tr) return "R5";
        return "R4";
    endfunction

    function automatic string tag_widen(logic [15:0] hw);
        if (hw[14:10] == 5'h1f) return "R8";
        if (hw[14:10] == 5'h0 && hw[9:0] != 0) return "R10";
        return "R9";
    endfunction

    initial begin
        rst_n = 1'b0;
        to_half_i = 1'b0; rmode_i = 2'd0; trunc_i = 1'b0; single_i = '0; half_i = '0;
        repeat (3) @(posedge clk);
        compare("R1 idle zero", 32'h0);
        rst_n = 1'b1;

        // R1: direction select, other operand ignored
        vec(1, 0, 0, 32'h3f800000, 16'h4000, 32'h00003c00, "R1");
        vec(0, 0, 0, 32'h3f800000, 16'h4000, 32'h40000000, "R1");
        vec(0, 3, 1, 32'h7fc00000, 16'h4000, 32'h40000000, "R1");
        // R2
        vec(1, 0, 0, 32'h7fc00000, 0, 32'h00007fff, "R2");
        vec(1, 2, 0, 32'hff800001, 0, 32'h00007fff, "R2");
        vec(1, 0, 0, 32'h7f800000, 0, 32'h00007c00, "R2");
        vec(1, 3, 0, 32'hff800000, 0, 32'h0000fc00, "R2");
        // R3
        vec(1, 2, 0, 32'h2e800000, 0, 32'h00000000, "R3");
        vec(1, 1, 0, 32'h80000001, 0, 32'h00008000, "R3");
        vec(1, 1, 0, 32'hae8fffff, 0, 32'h00008000, "R3");
        // R4
        vec(1, 0, 0, 32'h3f800000, 0, 32'h00003c00, "R4");
        vec(1, 0, 0, 32'h3f801000, 0, 32'h00003c00, "R4");
        vec(1, 2, 0, 32'h3f801000, 0, 32'h00003c01, "R4");
        vec(1, 0, 0, 32'h3f803000, 0, 32'h00003c02, "R4");
        vec(1, 1, 0, 32'hbf801000, 0, 32'h0000bc01, "R4");
        vec(1, 2, 0, 32'hbf801000, 0, 32'h0000bc00, "R4");
        // R5
        vec(1, 0, 1, 32'h3f801fff, 0, 32'h00003c00, "R5");
        vec(1, 2, 1, 32'h3f801fff, 0, 32'h00003c00, "R5");
        vec(1, 1, 1, 32'hbf801fff, 0, 32'h0000bc00, "R5");
        // R6
        vec(1, 2, 0, 32'h2f000000, 0, 32'h00000001, "R6");
        vec(1, 0, 0, 32'h2f000000, 0, 32'h00000000, "R6");
        vec(1, 0, 0, 32'h33800000, 0, 32'h00000001, "R6");
        vec(1, 0, 0, 32'h38000000, 0, 32'h00000200, "R6");
        vec(1, 0, 0, 32'h387fffff, 0, 32'h00000400, "R6");
        // R7
        vec(1, 0, 0, 32'h477fe000, 0, 32'h00007bff, "R7");
        vec(1, 0, 0, 32'h477ff000, 0, 32'h00007c00, "R7");
        vec(1, 3, 0, 32'h477ff000, 0, 32'h00007bff, "R7");
        vec(1, 2, 0, 32'hc77ff000, 0, 32'h0000fbff, "R7");
        vec(1, 1, 0, 32'hc77ff000, 0, 32'h0000fc00, "R7");
        vec(1, 0, 0, 32'h501502f9, 0, 32'h00007c00, "R7");
        vec(1, 0, 1, 32'h501502f9, 0, 32'h00007bff, "R7");
        // R8
        vec(0, 0, 0, 0, 16'h7e00, 32'h7fffffff, "R8");
        vec(0, 0, 0, 0, 16'hfc01, 32'h7fffffff, "R8");
        vec(0, 0, 0, 0, 16'hfc00, 32'hff800000, "R8");
        // R9
        vec(0, 0, 0, 0, 16'h3c00, 32'h3f800000, "R9");
        vec(0, 0, 0, 0, 16'h8000, 32'h80000000, "R9");
        vec(0, 0, 0, 0, 16'h7bff, 32'h477fe000, "R9");
        // R10
        vec(0, 0, 0, 0, 16'h0001, 32'h33800000, "R10");
        vec(0, 0, 0, 0, 16'h03ff, 32'h387fc000, "R10");
        vec(0, 0, 0, 0, 16'h8200, 32'hb8000000, "R10");

        for (int i = 0; i < 4000; i++) begin
            bit          th = 1'($urandom);
            logic [1:0]  rm = 2'($urandom);
            bit          tr = ($urandom % 5) == 0;
            logic [31:0] sw = $urandom;
            logic [15:0] hw = 16'($urandom);
            logic [15:0] en;
            if ($urandom % 2) sw[30:23] = 8'(88 + $urandom % 60);
            apply(th, rm, tr, sw, hw);
            if (th) begin
                en = model_narrow(sw, rm, tr);
                compare(tag_narrow(sw, tr, en), {16'h0, en});
            end else begin
                compare(tag_widen(hw), model_widen(hw));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule